// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits between a host write port and the page-load logic of a non-volatile memory array. It watches every qualified write strobe, together with its address and low data byte, for short fixed command sequences. One sequence turns write protection on. The same sequence also acts as a one-shot key that opens the array for the page load that immediately follows. A longer sequence turns protection off.

For each strobe the block makes one of three decisions in the same cycle. The strobe is either a command step, which is never stored, or a permitted array write, or a dummy cycle. A dummy cycle asks the programming timer to run as if a write had happened, but leaves the array contents unchanged. The protection flag survives the ordinary synchronous reset. Only a separate power-on initialization input clears it.

Command writes must arrive close together. A gap longer than the load window abandons a partly entered sequence. The same gap closes the key that an enable sequence opened.

Top module: `wrprot_gate`

## Requirements
- R1: Asserting `por_init` clears `prot_on` to 0. With protection off, a write that is not a command step gives `wr_permit`=1.
- R2: The enable sequence sets `prot_on` to 1 in the cycle after its third write. The sequence is three writes: data 0xAA to address 0x5555, then data 0x55 to address 0x2AAA, then data 0xA0 to address 0x5555.
- R3: A strobe that matches the next expected command step gives `wr_permit`=0 and `dummy_req`=0 in its own cycle, whether or not protection is on.
- R4: With protection off, a strobe that is not a command step gives `wr_permit`=1 and `dummy_req`=0 in the same cycle.
- R5: With protection on and no key open, a strobe that is not a command step gives `wr_permit`=0 and `dummy_req`=1 in the same cycle.
- R6: After a completed enable sequence, each following non-command write gives `wr_permit`=1, as long as it comes within the load window of the previous write. Once a gap exceeds the window, writes are unkeyed again.
- R7: The disable sequence clears `prot_on` in the cycle after its sixth write. The sequence is six writes, as (address/data): 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20.
- R8: A strobe that does not match the expected next step returns the matcher to idle. That strobe is handled as a data write (permitted or dummy) and is not treated as a new first step.
- R9: Consecutive strobes may be at most `WINDOW_CYC` cycles apart and still continue a sequence. A spacing of `WINDOW_CYC`+1 or more abandons the sequence.
- R10: `rst` leaves `prot_on` unchanged. It returns the matcher to idle and closes any open key.
- R11: Command matching compares only address bits [14:0], so address 0x15555 counts as 0x5555.
- R12: The command addresses can hold ordinary data. A write to 0x5555 with data that is not a command code is permitted when protection is off or a key is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the matcher, the key and the window timer |
| por_init | input | 1 | Synchronous power-on initialization; also clears protection |
| wr_stb | input | 1 | Qualified host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bits [7:0] are compared against the command codes |
| prot_on | output | 1 | Protection enabled |
| wr_permit | output | 1 | This strobe may be stored in the page buffer |
| dummy_req | output | 1 | This strobe starts the programming timer without storing data |

## Verification
Every data value is swept at the first command address while protection is on. Exactly one value (0xAA) must be taken as a command, and every other value must produce a dummy cycle; this separates the command decode from the protection gating. The spacing between the first two command writes is swept from one cycle up past the window. This pins the boundary at exactly `WINDOW_CYC` and tells an off-by-one in the timer apart from a matcher fault. Several further cases tell a sequence that was abandoned apart from one that was never started, and a cleared key apart from a cleared protection flag: interrupted sequences, a reset in the middle of a sequence, a reset while a key is open, high address bits, and the full disable sequence.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;

    localparam int CMD_AW = 15;
    localparam int CODE_W = 8;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [CODE_W-1:0] CODE_FIRST  = 8'hAA;
    localparam logic [CODE_W-1:0] CODE_SECOND = 8'h55;
    localparam logic [CODE_W-1:0] CODE_LOCK   = 8'hA0;
    localparam logic [CODE_W-1:0] CODE_EXTEND = 8'h80;
    localparam logic [CODE_W-1:0] CODE_FREE   = 8'h20;

    // Progress through the command sequences; the disable sequence shares
    // its first two steps with the enable sequence.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_E1,
        SQ_E2,
        SQ_D3,
        SQ_D4,
        SQ_D5
    } seq_state_t;

    typedef struct packed {
        logic       hit;
        logic       arm;
        logic       disarm;
        seq_state_t nxt;
    } step_res_t;

    function automatic step_res_t eval_step(
        input seq_state_t        cur,
        input logic [CMD_AW-1:0] a,
        input logic [CODE_W-1:0] d
    );
        step_res_t r;
        logic at_a;
        logic at_b;
        r     = '0;
        r.nxt = SQ_IDLE;
        at_a  = (a == KEY_ADDR_A);
        at_b  = (a == KEY_ADDR_B);
        case (cur)
            SQ_IDLE: if (at_a && d == CODE_FIRST) begin
                r.hit = 1'b1; r.nxt = SQ_E1;
            end
            SQ_E1: if (at_b && d == CODE_SECOND) begin
                r.hit = 1'b1; r.nxt = SQ_E2;
            end
            SQ_E2: begin
                if (at_a && d == CODE_LOCK) begin
                    r.hit = 1'b1; r.arm = 1'b1; r.nxt = SQ_IDLE;
                end else if (at_a && d == CODE_EXTEND) begin
                    r.hit = 1'b1; r.nxt = SQ_D3;
                end
            end
            SQ_D3: if (at_a && d == CODE_FIRST) begin
                r.hit = 1'b1; r.nxt = SQ_D4;
            end
            SQ_D4: if (at_b && d == CODE_SECOND) begin
                r.hit = 1'b1; r.nxt = SQ_D5;
            end
            SQ_D5: if (at_a && d == CODE_FREE) begin
                r.hit = 1'b1; r.disarm = 1'b1; r.nxt = SQ_IDLE;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wrprot_window.sv
module wrprot_window #(
    parameter int WINDOW_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic expire
);
    localparam int CW = $clog2(WINDOW_CYC + 1);
    localparam logic [CW-1:0] LIM  = CW'(WINDOW_CYC);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYC - 1);

    logic [CW-1:0] gap_q;

    // Fires in the idle cycle that ends the window.
    assign expire = !stb && (gap_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= LIM;
        end else if (stb) begin
            gap_q <= '0;
        end else if (gap_q != LIM) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_WIN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        gap_q <= LIM);                                             // R9
    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (rst)
        stb |=> gap_q == '0);                                      // R9

endmodule

// File: rtl/wrprot_matcher.sv
module wrprot_matcher
    import wrprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [CMD_AW-1:0] addr,
    input  logic [CODE_W-1:0] data,
    input  logic              expire,
    output logic              cmd_hit,
    output logic              arm,
    output logic              disarm
);
    seq_state_t state_q;
    step_res_t  res;

    always_comb begin
        res     = eval_step(state_q, addr, data);
        cmd_hit = stb && res.hit;
        arm     = stb && res.arm;
        disarm  = stb && res.disarm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
        end else if (stb) begin
            state_q <= res.nxt;
        end else if (expire) begin
            state_q <= SQ_IDLE;
        end
    end

    AST_SEQ_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        expire |=> state_q == SQ_IDLE);                            // R9
    AST_MISS_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (stb && !cmd_hit) |=> state_q == SQ_IDLE);                 // R8
    AST_DISARM_END: assert property (@(posedge clk) disable iff (rst)
        disarm |=> state_q == SQ_IDLE);                            // R7

endmodule

// File: rtl/wrprot_keystate.sv
module wrprot_keystate (
    input  logic clk,
    input  logic rst,
    input  logic por_init,
    input  logic arm,
    input  logic disarm,
    input  logic expire,
    output logic prot_q,
    output logic unlock_q
);
    // Protection is cleared only by power-on initialization or disable.
    always_ff @(posedge clk) begin
        if (por_init) begin
            prot_q <= 1'b0;
        end else if (arm) begin
            prot_q <= 1'b1;
        end else if (disarm) begin
            prot_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (por_init || rst) begin
            unlock_q <= 1'b0;
        end else if (arm) begin
            unlock_q <= 1'b1;
        end else if (disarm || expire) begin
            unlock_q <= 1'b0;
        end
    end

    AST_PROT_KEEP_RST: assert property (@(posedge clk) disable iff (por_init)
        (rst && !arm && !disarm) |=> prot_q == $past(prot_q));     // R10
    AST_ARM_PROTECTS: assert property (@(posedge clk) disable iff (por_init)
        arm |=> prot_q);                                           // R2
    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (por_init)
        disarm |=> !prot_q);                                       // R7
    AST_KEY_NEEDS_PROT: assert property (@(posedge clk) disable iff (por_init || rst)
        unlock_q |-> prot_q);                                      // R6

endmodule

// File: rtl/wrprot_gate.sv
module wrprot_gate
    import wrprot_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int WINDOW_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_init,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_on,
    output logic              wr_permit,
    output logic              dummy_req
);
    logic expire;
    logic cmd_hit;
    logic arm;
    logic disarm;
    logic prot_q;
    logic unlock_q;

    generate
        if (ADDR_W > CMD_AW) begin : g_addr_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^wr_addr[ADDR_W-1:CMD_AW];
        end
        if (DATA_W > CODE_W) begin : g_data_hi
            logic unused_data_hi;
            assign unused_data_hi = ^wr_data[DATA_W-1:CODE_W];
        end
    endgenerate

    wrprot_window #(.WINDOW_CYC(WINDOW_CYC)) u_window (
        .clk    (clk),
        .rst    (rst || por_init),
        .stb    (wr_stb),
        .expire (expire)
    );

    wrprot_matcher u_matcher (
        .clk     (clk),
        .rst     (rst || por_init),
        .stb     (wr_stb),
        .addr    (wr_addr[CMD_AW-1:0]),
        .data    (wr_data[CODE_W-1:0]),
        .expire  (expire),
        .cmd_hit (cmd_hit),
        .arm     (arm),
        .disarm  (disarm)
    );

    wrprot_keystate u_keystate (
        .clk      (clk),
        .rst      (rst),
        .por_init (por_init),
        .arm      (arm),
        .disarm   (disarm),
        .expire   (expire),
        .prot_q   (prot_q),
        .unlock_q (unlock_q)
    );

    assign prot_on   = prot_q;
    assign wr_permit = wr_stb && !cmd_hit && (!prot_q || unlock_q);
    assign dummy_req = wr_stb && !cmd_hit && prot_q && !unlock_q;

    AST_CMD_NOT_STORED: assert property (@(posedge clk) disable iff (rst || por_init)
        cmd_hit |-> !wr_permit && !dummy_req);                     // R3
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst || por_init)
        wr_stb |-> $countones({cmd_hit, wr_permit, dummy_req}) == 1); // R4
    AST_NO_IDLE_ACTION: assert property (@(posedge clk) disable iff (rst || por_init)
        !wr_stb |-> !wr_permit && !dummy_req && !cmd_hit);         // R5

endmodule

// File: tb/wrprot_gate_bench.sv
module wrprot_gate_bench;
    localparam int CLK_P = 10;
    localparam int WIN   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_init = 1'b1;
    logic        wr_stb = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prot_on;
    logic        wr_permit;
    logic        dummy_req;

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    wrprot_gate #(.ADDR_W(17), .DATA_W(8), .WINDOW_CYC(WIN)) u_wrprot_gate (
        .clk       (clk),
        .rst       (rst),
        .por_init  (por_init),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prot_on   (prot_on),
        .wr_permit (wr_permit),
        .dummy_req (dummy_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One strobe; outputs checked in the strobe cycle.
    task automatic wr(input logic [16:0] a, input logic [7:0] d,
                      input logic ep, input logic ed, input string tag);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        #1;
        chk({tag, " permit"}, wr_permit, ep);
        chk({tag, " dummy"}, dummy_req, ed);
        @(posedge clk);
        #1 wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chkp(input logic exp, input string tag);
        @(negedge clk);
        chk({tag, " prot_on"}, prot_on, exp);
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic enable_seq(input logic [16:0] hi, input string tag);
        wr(hi | 17'h05555, 8'hAA, 1'b0, 1'b0, tag);
        wr(hi | 17'h02AAA, 8'h55, 1'b0, 1'b0, tag);
        wr(hi | 17'h05555, 8'hA0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0; por_init = 1'b0;
        chkp(1'b0, "R1 reset state");

        // Unprotected data writes, including to a command address
        wr(17'h05555, 8'h12, 1'b1, 1'b0, "R12 data at command address");
        wr(17'h00100, 8'h34, 1'b1, 1'b0, "R4 plain write");

        // Enable from unprotected: steps not stored
        enable_seq(17'h0, "R3 enable steps unprotected");
        chkp(1'b1, "R2 enabled");
        wr(17'h00101, 8'h01, 1'b1, 1'b0, "R6 keyed write 1");
        wr(17'h05555, 8'h12, 1'b1, 1'b0, "R12 keyed write at command address");
        idle(WIN);
        wr(17'h00102, 8'h02, 1'b0, 1'b1, "R5 unkeyed after window");

        // Sweep all data values at the first command address
        for (int d = 0; d < 256; d++) begin
            idle(WIN);
            wr(17'h05555, 8'(d), 1'b0, (d != 8'hAA), "R5 R3 data sweep");
        end

        // Key window boundary
        idle(WIN);
        enable_seq(17'h0, "R3 enable steps protected");
        idle(WIN - 1);
        wr(17'h00200, 8'h11, 1'b1, 1'b0, "R6 keyed at window limit");
        idle(WIN - 1);
        wr(17'h00201, 8'h22, 1'b1, 1'b0, "R6 keyed second at limit");
        idle(WIN);
        wr(17'h00202, 8'h33, 1'b0, 1'b1, "R6 key closed past window");

        // Spacing sweep between command steps
        for (int n = 0; n <= WIN + 1; n++) begin
            idle(WIN);
            wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R9 first step");
            idle(n);
            wr(17'h02AAA, 8'h55, 1'b0, (n > WIN - 1), "R9 spacing sweep");
        end

        // Mismatch handling
        idle(WIN);
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R8 first step");
        wr(17'h02AAB, 8'h55, 1'b0, 1'b1, "R8 wrong address is data");
        wr(17'h05555, 8'hA0, 1'b0, 1'b1, "R8 no resume after miss");
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R8 restart");
        wr(17'h05555, 8'hAA, 1'b0, 1'b1, "R8 repeated first step is data");
        chkp(1'b1, "R8 still protected");

        // Reset behaviour
        pulse_rst();
        chkp(1'b1, "R10 reset keeps protection");
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R10 step 1");
        wr(17'h02AAA, 8'h55, 1'b0, 1'b0, "R10 step 2");
        pulse_rst();
        wr(17'h05555, 8'hA0, 1'b0, 1'b1, "R10 reset aborts sequence");
        idle(WIN);
        enable_seq(17'h0, "R10 enable");
        pulse_rst();
        wr(17'h00300, 8'h44, 1'b0, 1'b1, "R10 reset closes key");

        // High address bits ignored by the matcher
        idle(WIN);
        enable_seq(17'h10000, "R11 enable with high bit");
        wr(17'h10400, 8'h55, 1'b1, 1'b0, "R11 keyed after high-bit sequence");

        // Disable
        idle(WIN);
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R7 step 1");
        wr(17'h02AAA, 8'h55, 1'b0, 1'b0, "R7 step 2");
        wr(17'h05555, 8'h80, 1'b0, 1'b0, "R7 step 3");
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R7 step 4");
        wr(17'h02AAA, 8'h55, 1'b0, 1'b0, "R7 step 5");
        wr(17'h05555, 8'h20, 1'b0, 1'b0, "R7 step 6");
        chkp(1'b0, "R7 disabled");
        idle(WIN);
        wr(17'h00500, 8'h66, 1'b1, 1'b0, "R4 write after disable");

        // Power-on initialization clears protection
        idle(WIN);
        enable_seq(17'h0, "R1 enable");
        chkp(1'b1, "R1 enabled before init");
        @(negedge clk); por_init = 1'b1;
        @(negedge clk); por_init = 1'b0;
        chkp(1'b0, "R1 init clears protection");
        wr(17'h00600, 8'h77, 1'b1, 1'b0, "R1 write after init");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule